// File: doc/BRIEF.md
# Iterative Shift-Add Approximate Multiplier

This block multiplies two 8-bit unsigned operands without an array multiplier. It splits each operand into its highest set bit and the bits below it, so that A = 2^j + AR and B = 2^k + BR. The product then breaks into three terms that need only shifts: 2^(j+k), BR shifted left by j, and AR shifted left by k. One more term, AR·BR, is left over. The block adds the three shifted terms into an accumulator and treats the leftover pair (AR, BR) as the operands of the next step. Each step takes one clock cycle.

The caller pulses `start` with the two operands and an iteration limit. A limit of zero runs until no residual is left, and the result is then the exact product. A limit of N stops after N steps. The result then falls short of the true product by exactly the residual product that was not expanded. That shortfall is below one quarter of the product after one step and shrinks by four times with each further step. A low limit therefore buys fewer adder cycles and less switching at the cost of accuracy. For one cycle, `done` marks the moment `product` and `exact` take their new values. Both then hold until the next completion.

Top module: `diglog_mul`

## Requirements
- R1: While reset is high and in the first cycle after it, `done`, `exact` and `product` are all zero.
- R2: A start with either operand equal to zero raises `done` in the cycle right after the start edge, with `product` = 0 and `exact` = 1, and takes no iteration cycles.
- R3: With both operands nonzero, each step of decomposition takes exactly one clock after the start edge. `done` rises in the cycle after the edge that performs the last step, and no further step is performed after the residual pair contains a zero.
- R4: With `iter_lim` = 0, the result equals a·b, `exact` = 1, and the computation takes at most eight steps. 255·255 is the case that needs all eight.
- R5: `iter_lim` is an unsigned step count. With `iter_lim` = N ≥ 1, the block stops after min(N, steps needed) steps. `exact` = 1 only if the residual pair held a zero at the stopping point, and otherwise `exact` = 0.
- R6: The result never exceeds a·b. After n steps without reaching exactness, (a·b − product)·4^n < a·b.
- R7: A `start` pulse that arrives while a computation is in progress is ignored. The running result is not disturbed and no extra completion follows.
- R8: `done` is high for one cycle for each accepted start. `product` and `exact` change only in a cycle where `done` is high.
- R9: An operand that is a power of two ends the computation after one step with the exact product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Requests a multiply; accepted only while idle |
| a | input | 8 | First unsigned operand |
| b | input | 8 | Second unsigned operand |
| iter_lim | input | 4 | Step limit; 0 means run until exact |
| product | output | 16 | Result of the last completed multiply |
| done | output | 1 | One-cycle completion strobe |
| exact | output | 1 | Result of the last completed multiply is exact |

## Verification
The bench goes after operands that stop at different depths. Zero operands must finish with no step at all. Powers of two must finish after a single step, and 255·255 needs eight steps. A design whose stop test lagged by a cycle would show `done` one cycle late, and its accumulator would hold a sum that was not wanted. The bench sweeps every limit from 1 to 8 across deep operand pairs. A limit compare that was off by one would give the wrong shortfall or a wrong `exact` flag, and one that let `exact` depend on the limit rather than the residual would mislabel a result that happens to be exact at the limit. Start pulses arriving during a run check that a busy sequencer does not reload its operands. Idle gaps with changing inputs check that the result does not drift between completions.

// File: rtl/diglog_pkg.sv
package diglog_pkg;

    localparam int OP_W     = 8;
    localparam int PROD_W   = 2 * OP_W;
    localparam int IDX_W    = $clog2(OP_W);
    localparam int MAX_ITER = OP_W;
    localparam int CNT_W    = $clog2(MAX_ITER + 1);

    typedef logic [OP_W-1:0]   opnd_t;
    typedef logic [PROD_W-1:0] prod_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } seq_e;

    // highest set bit position and the operand with that bit removed
    typedef struct packed {
        idx_t  pos;
        opnd_t rem;
    } lead_t;

    // result of one decomposition step
    typedef struct packed {
        prod_t term;
        opnd_t xr;
        opnd_t yr;
        logic  last;
    } step_t;

    function automatic prod_t widen(opnd_t v);
        return {{(PROD_W-OP_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/diglog_lod.sv
module diglog_lod
    import diglog_pkg::*;
(
    input  opnd_t val,
    output lead_t lead
);

    opnd_t above;
    opnd_t hot;

    generate
        for (genvar i = 0; i < OP_W; i++) begin : g_bit
            if (i == OP_W - 1) begin : g_top
                assign above[i] = 1'b0;
            end else begin : g_low
                assign above[i] = |val[OP_W-1:i+1];
            end
            assign hot[i] = val[i] & ~above[i];
        end
    endgenerate

    always_comb begin
        lead.pos = '0;
        for (int i = 0; i < OP_W; i++) begin
            if (hot[i]) begin
                lead.pos = lead.pos | idx_t'(i);
            end
        end
        lead.rem = val & ~hot;
    end

endmodule

// File: rtl/diglog_step.sv
module diglog_step
    import diglog_pkg::*;
(
    input  opnd_t x,
    input  opnd_t y,
    output step_t res
);

    lead_t            lx;
    lead_t            ly;
    logic [IDX_W:0]   sh_sum;

    diglog_lod u_lod_x (
        .val  (x),
        .lead (lx)
    );

    diglog_lod u_lod_y (
        .val  (y),
        .lead (ly)
    );

    always_comb begin
        sh_sum   = {1'b0, lx.pos} + {1'b0, ly.pos};
        res.term = (prod_t'(1) << sh_sum)
                 + (widen(ly.rem) << lx.pos)
                 + (widen(lx.rem) << ly.pos);
        res.xr   = lx.rem;
        res.yr   = ly.rem;
        res.last = ~(|lx.rem) | ~(|ly.rem);
    end

endmodule

// File: rtl/diglog_mul.sv
module diglog_mul
    import diglog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    input  logic [CNT_W-1:0]  iter_lim,
    output logic [PROD_W-1:0] product,
    output logic              done,
    output logic              exact
);

    seq_e  st;
    opnd_t x_q;
    opnd_t y_q;
    prod_t acc_q;
    cnt_t  cnt_q;
    cnt_t  lim_q;
    step_t stp;

    prod_t acc_n;
    cnt_t  cnt_n;
    logic  hit_lim;
    logic  zero_in;

    diglog_step u_step (
        .x   (x_q),
        .y   (y_q),
        .res (stp)
    );

    always_comb begin
        acc_n   = acc_q + stp.term;
        cnt_n   = cnt_q + cnt_t'(1);
        hit_lim = (lim_q != '0) && (cnt_n == lim_q);
        zero_in = ~(|a) | ~(|b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            x_q     <= '0;
            y_q     <= '0;
            acc_q   <= '0;
            cnt_q   <= '0;
            lim_q   <= '0;
            product <= '0;
            done    <= 1'b0;
            exact   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        lim_q <= iter_lim;
                        cnt_q <= '0;
                        acc_q <= '0;
                        x_q   <= a;
                        y_q   <= b;
                        if (zero_in) begin
                            product <= '0;
                            exact   <= 1'b1;
                            done    <= 1'b1;
                        end else begin
                            st <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    acc_q <= acc_n;
                    cnt_q <= cnt_n;
                    x_q   <= stp.xr;
                    y_q   <= stp.yr;
                    if (stp.last || hit_lim) begin
                        product <= acc_n;
                        exact   <= stp.last;
                        done    <= 1'b1;
                        st      <= ST_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/diglog_mul_chk.sv
module diglog_mul_chk
    import diglog_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [OP_W-1:0]   a,
    input logic [OP_W-1:0]   b,
    input logic [CNT_W-1:0]  iter_lim,
    input logic [PROD_W-1:0] product,
    input logic              done,
    input logic              exact
);

    logic           busy_c;
    opnd_t          oa;
    opnd_t          ob;
    cnt_t           lim_c;
    logic [CNT_W:0] cyc_c;
    prod_t          ref_p;
    logic           accept;

    assign accept = start && (!busy_c || done);
    assign ref_p  = widen(oa) * widen(ob);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_c <= 1'b0;
            oa     <= '0;
            ob     <= '0;
            lim_c  <= '0;
            cyc_c  <= '0;
        end else if (accept) begin
            oa     <= a;
            ob     <= b;
            lim_c  <= iter_lim;
            cyc_c  <= '0;
            busy_c <= (a != '0) && (b != '0);
        end else if (done) begin
            busy_c <= 1'b0;
        end else if (busy_c) begin
            cyc_c <= cyc_c + 1'b1;
        end
    end

    // R2
    a_r2_zero_operand: assert property (@(posedge clk) disable iff (rst)
        (accept && (a == '0 || b == '0)) |=> (done && exact && product == '0));

    // R4
    a_r4_exact_value: assert property (@(posedge clk) disable iff (rst)
        (done && exact) |-> (product == ref_p));

    // R3 and R4: step count stays within the worst case
    a_r3_step_bound: assert property (@(posedge clk) disable iff (rst)
        busy_c |-> (cyc_c <= (CNT_W+1)'(MAX_ITER)));

    // R5
    a_r5_inexact_needs_limit: assert property (@(posedge clk) disable iff (rst)
        (done && !exact) |-> (lim_c != '0));

    // R6
    a_r6_underestimate: assert property (@(posedge clk) disable iff (rst)
        done |-> (product <= ref_p));

    // R8
    a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(product) && $stable(exact)));

endmodule

bind diglog_mul diglog_mul_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .a        (a),
    .b        (b),
    .iter_lim (iter_lim),
    .product  (product),
    .done     (done),
    .exact    (exact)
);

// File: tb/diglog_mul_tb.sv
`timescale 1ns/1ps
module diglog_mul_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [3:0]  iter_lim;
    logic [15:0] product;
    logic        done;
    logic        exact;

    int    vectors = 0;
    int    fails   = 0;
    string cur_tag = "R1";
    bit    checking = 1'b0;

    // reference model state
    bit          m_busy;
    int          m_left;
    int          m_res_p;
    bit          m_res_x;
    int          m_a, m_b, m_n;
    logic [15:0] e_prod;
    logic        e_done;
    logic        e_exact;
    int          d_a, d_b, d_n;

    always #5 clk = ~clk;

    diglog_mul dut_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .a        (a),
        .b        (b),
        .iter_lim (iter_lim),
        .product  (product),
        .done     (done),
        .exact    (exact)
    );

    function automatic int top_bit(int v);
        int p = 0;
        for (int i = 0; i < 8; i++) if (v[i]) p = i;
        return p;
    endfunction

    // expected result of a multiply: product, exactness, steps taken
    task automatic ref_calc(input int ia, input int ib, input int il,
                            output int p, output bit ex, output int n);
        int x = ia;
        int y = ib;
        int xr = 0;
        int yr = 0;
        n  = 0;
        ex = 1'b1;
        if (ia == 0 || ib == 0) begin
            p = 0;
            return;
        end
        forever begin
            xr = x - (1 << top_bit(x));
            yr = y - (1 << top_bit(y));
            n++;
            if (xr == 0 || yr == 0) begin
                ex = 1'b1;
                break;
            end
            if (il != 0 && n == il) begin
                ex = 1'b0;
                break;
            end
            x = xr;
            y = yr;
        end
        p = ia * ib - xr * yr;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy  = 1'b0;
            m_left  = 0;
            e_done  = 1'b0;
            e_prod  = '0;
            e_exact = 1'b0;
        end else begin
            e_done = 1'b0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    e_done  = 1'b1;
                    e_prod  = 16'(m_res_p);
                    e_exact = m_res_x;
                    m_busy  = 1'b0;
                    d_a = m_a; d_b = m_b; d_n = m_n;
                end
            end else if (start) begin
                ref_calc(int'(a), int'(b), int'(iter_lim), m_res_p, m_res_x, m_n);
                m_a = int'(a);
                m_b = int'(b);
                if (m_n == 0) begin
                    e_done  = 1'b1;
                    e_prod  = '0;
                    e_exact = 1'b1;
                    d_a = m_a; d_b = m_b; d_n = 0;
                end else begin
                    m_busy = 1'b1;
                    m_left = m_n;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            vectors++;
            if (done !== e_done || product !== e_prod || exact !== e_exact) begin
                fails++;
                $display("FAIL %s: done=%b/%b product=%0d/%0d exact=%b/%b (actual/expected)",
                         cur_tag, done, e_done, product, e_prod, exact, e_exact);
            end
            if (e_done && done === 1'b1) begin
                longint tru;
                longint err;
                tru = longint'(d_a) * longint'(d_b);
                err = tru - longint'(product);
                vectors++;
                // R6: never above the true product, shortfall below a*b/4^n
                if (err < 0 || (err != 0 && err * (longint'(1) << (2 * d_n)) >= tru)) begin
                    fails++;
                    $display("FAIL R6: %0d*%0d after %0d steps product=%0d expected within bound of %0d",
                             d_a, d_b, d_n, product, tru);
                end
                // R4 and R5: an exact flag must mean an exact value
                if (exact === 1'b1 && err != 0) begin
                    fails++;
                    $display("FAIL R4 R5: %0d*%0d flagged exact product=%0d expected %0d",
                             d_a, d_b, product, tru);
                end
            end
        end
    end

    task automatic run_op(input int ia, input int ib, input int il, input string tag);
        cur_tag  = tag;
        a        = 8'(ia);
        b        = 8'(ib);
        iter_lim = 4'(il);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_busy) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected completion");
        summary();
    end

    initial begin
        logic [15:0] lfsr;
        int          cyc;
        rst      = 1'b1;
        start    = 1'b0;
        a        = '0;
        b        = '0;
        iter_lim = '0;
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        vectors++;
        if (done !== 1'b0 || exact !== 1'b0 || product !== 16'd0) begin
            fails++;
            $display("FAIL R1: done=%b exact=%b product=%0d expected 0 0 0", done, exact, product);
        end
        rst = 1'b0;
        checking = 1'b1;
        @(negedge clk);

        // R2: zero operands
        run_op(0, 37, 0, "R2");
        run_op(200, 0, 3, "R2");
        run_op(0, 0, 1, "R2");
        cur_tag = "R2";
        a = 8'd0; b = 8'd5; start = 1'b1;
        repeat (4) @(negedge clk);
        start = 1'b0;
        @(negedge clk);

        // R9: powers of two
        run_op(64, 201, 0, "R9");
        run_op(173, 1, 0, "R9");
        run_op(128, 128, 1, "R9");

        // R3 and R4: full-depth runs, step count measured at the ports
        cur_tag  = "R3";
        a = 8'd255; b = 8'd255; iter_lim = 4'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (done !== 1'b1 && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        vectors++;
        if (cyc != 9) begin
            fails++;
            $display("FAIL R3: 255*255 done after %0d cycles, expected 9", cyc);
        end
        @(negedge clk);
        run_op(3, 5, 0, "R4");
        run_op(170, 85, 0, "R4");
        run_op(13, 11, 0, "R4");
        run_op(127, 254, 0, "R4");

        // R5 and R6: every limit on deep pairs
        for (int l = 1; l <= 8; l++) begin
            run_op(255, 255, l, "R5");
            run_op(200, 150, l, "R6");
            run_op(99, 77, l, "R5");
        end

        // R7: starts during a run are ignored
        cur_tag  = "R7";
        a = 8'd255; b = 8'd255; iter_lim = 4'd0; start = 1'b1;
        @(negedge clk);
        a = 8'd0; b = 8'd9;
        repeat (4) @(negedge clk);
        start = 1'b0;
        while (m_busy) @(negedge clk);
        @(negedge clk);

        // R8: idle with moving inputs, result must hold
        cur_tag = "R8";
        for (int i = 0; i < 6; i++) begin
            a = 8'(i * 37);
            b = 8'(i * 91);
            iter_lim = 4'(i);
            @(negedge clk);
        end

        // sweep across operands and limits
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            run_op(int'(lfsr[7:0]), int'(lfsr[15:8]), i % 9, "R3 R5 R6");
        end

        repeat (3) @(negedge clk);
        summary();
    end

endmodule